// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control half of an 8-bit successive-approximation converter with a multiplexed input. A pulse on `start` arms the sequencer. While `start` stays high, all conversion state is held cleared. On the first clock edge after `start` falls, the block opens a one-cycle sample window. It then drives a trial code to an external DAC and resolves one bit per clock, most significant bit first, using a single comparator decision input. After the last decision it loads the finished code into an output register and raises the end-of-conversion flag.

The result register is double-buffered. The previous code stays on the bus for the whole of the next conversion and changes only when a conversion completes. If `start` is pulsed again mid-conversion, the work in progress is abandoned and a fresh conversion begins. A channel address is captured on the rising edge of the address strobe. The data bus is modelled as a data word plus a drive-enable. Tying `start` to `eoc` makes the block convert continuously. The analog multiplexer, DAC, comparator and sample-and-hold are outside the block.

Top module: `sar_conv_seq`

## Requirements
- R1: While `arst_n` is low, and until the internal reset is released two clock edges after `arst_n` rises, `eoc` is 1, `sample_en` is 0, `chan_sel` is 0 and the result register is 0x00.
- R2: While `start` is sampled high, `sample_en` stays 0 and `eoc` is driven to 0. On the first rising edge that samples `start` low after that, `sample_en` goes to 1 for exactly one cycle.
- R3: Counting rising edges after the last edge that sampled `start` high, `eoc` returns to 1 on the 10th edge: one edge into sampling, one into the first trial and eight decision edges.
- R4: The loaded result is the code built from eight decisions taken MSB first. A bit stays 1 when `cmp_hi` is 1, meaning the input is at or above the DAC level. With an ideal comparator, a conversion of input level v yields v for every v in 0..255.
- R5: On the edge that ends the sample window, `dac_code` becomes 0x80. On the next edge, bit 7 takes the value of `cmp_hi` and bit 6 is set, giving 0xC0 or 0x40.
- R6: The result register keeps its previous value throughout a conversion and changes only on the edge where `eoc` rises.
- R7: A `start` pulse during a conversion restarts the sequence. `eoc` stays 0 and the abandoned code is never loaded into the result register.
- R8: When `oe` is 0, `dout_en` is 0 and `dout` is all zeros. When `oe` is 1, `dout_en` is 1 and `dout` carries the result register.
- R9: `chan_sel` takes the value of `addr` on the clock edge that first sees `ale` high, in natural binary order (address n selects channel n). At all other times `addr` is ignored, including while `ale` is held high.
- R10: With `start` tied to `eoc`, the block converts continuously. Successive rises of `eoc` are 11 clock cycles apart, and each one delivers a correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Conversion request; high holds the sequencer cleared |
| ale | input | 1 | Address strobe; its rising edge captures `addr` |
| addr | input | 3 | Channel address |
| cmp_hi | input | 1 | Comparator decision: 1 when the input is at or above `dac_code` |
| oe | input | 1 | Bus drive request |
| sample_en | output | 1 | Sample switch control, high for the one-cycle sample window |
| dac_code | output | 8 | Trial code for the external DAC |
| eoc | output | 1 | End of conversion; low while a conversion is pending |
| chan_sel | output | 3 | Latched channel select for the analog multiplexer |
| dout | output | 8 | Result bus data (zero when not driven) |
| dout_en | output | 1 | Result bus drive-enable |

## Verification
A wrong state or bit index inside the sequencer shows up in two ways. The end-of-conversion rise moves away from the 10th edge, or the code on the bus differs from the ideal comparator's input level. Either is visible within one conversion, at most ten cycles after the fault. A corrupted trial register shows on `dac_code` on the very next edge, because the first two trial values are fixed by the requirements. A fault in the double buffering or in the restart path shows as a bus change while `eoc` is low, on the same edge the fault occurs.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_CONV   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_seq_pkg::*;
#(
  parameter int W = 8,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             sample_en,
  output logic             trial_clear,
  output logic             trial_init,
  output logic             decide,
  output logic             last,
  output logic [IDX_W-1:0] bit_idx,
  output logic             eoc
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(W - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             eoc_q, eoc_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    eoc_d   = eoc_q;
    if (start) begin
      state_d = ST_ARMED;
      idx_d   = '0;
      eoc_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_ARMED:  state_d = ST_SAMPLE;
        ST_SAMPLE: begin
          state_d = ST_CONV;
          idx_d   = TOP_IDX;
        end
        ST_CONV: begin
          if (idx_q == '0) begin
            state_d = ST_IDLE;
            eoc_d   = 1'b1;
          end else begin
            idx_d = idx_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      eoc_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      eoc_q   <= eoc_d;
    end
  end

  assign sample_en   = (state_q == ST_SAMPLE);
  assign trial_clear = start;
  assign trial_init  = (state_q == ST_SAMPLE) && !start;
  assign decide      = (state_q == ST_CONV) && !start;
  assign last        = (idx_q == '0);
  assign bit_idx     = idx_q;
  assign eoc         = eoc_q;
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int W = 8,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             init,
  input  logic             decide,
  input  logic             last,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp_hi,
  output logic [W-1:0]     trial,
  output logic [W-1:0]     result,
  output logic             load
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] trial_q, trial_d, decided;
  logic         trial_en;

  // resolve the bit under test and raise the next one
  always_comb begin
    decided          = trial_q;
    decided[bit_idx] = cmp_hi;
    if (bit_idx != '0) decided[bit_idx - 1'b1] = 1'b1;
  end

  always_comb begin
    trial_en = clear || init || decide;
    if (clear)      trial_d = '0;
    else if (init)  trial_d = MSB_ONLY;
    else            trial_d = decided;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trial_q <= '0;
    else if (trial_en) trial_q <= trial_d;
  end

  assign trial  = trial_q;
  assign result = decided;
  assign load   = decide && last;
endmodule

// File: rtl/sar_out_buf.sv
module sar_out_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] result_in,
  input  logic         oe,
  output logic [W-1:0] bus_data,
  output logic         bus_en
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (load) hold_q <= result_in;
  end

  assign bus_en   = oe;
  assign bus_data = oe ? hold_q : '0;
endmodule

// File: rtl/sar_chan_latch.sv
module sar_chan_latch #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] chan_sel
);
  logic          ale_q;
  logic [AW-1:0] chan_q;
  logic          capture;

  assign capture = ale && !ale_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q  <= 1'b0;
      chan_q <= '0;
    end else begin
      ale_q <= ale;
      if (capture) chan_q <= addr;
    end
  end

  assign chan_sel = chan_q;
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int W  = 8,
  parameter int AW = 3,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          start,
  input  logic          ale,
  input  logic [AW-1:0] addr,
  input  logic          cmp_hi,
  input  logic          oe,
  output logic          sample_en,
  output logic [W-1:0]  dac_code,
  output logic          eoc,
  output logic [AW-1:0] chan_sel,
  output logic [W-1:0]  dout,
  output logic          dout_en
);
  logic             rst_sync_n;
  logic             trial_clear, trial_init, decide, last, load;
  logic [IDX_W-1:0] bit_idx;
  logic [W-1:0]     result;

  sar_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_sync_n)
  );

  sar_seq_fsm #(.W(W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .start(start),
    .sample_en(sample_en), .trial_clear(trial_clear), .trial_init(trial_init),
    .decide(decide), .last(last), .bit_idx(bit_idx), .eoc(eoc)
  );

  sar_trial_reg #(.W(W)) u_trial (
    .clk(clk), .rst_n(rst_sync_n), .clear(trial_clear), .init(trial_init),
    .decide(decide), .last(last), .bit_idx(bit_idx), .cmp_hi(cmp_hi),
    .trial(dac_code), .result(result), .load(load)
  );

  sar_out_buf #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .result_in(result),
    .oe(oe), .bus_data(dout), .bus_en(dout_en)
  );

  sar_chan_latch #(.AW(AW)) u_chan (
    .clk(clk), .rst_n(rst_sync_n), .ale(ale), .addr(addr), .chan_sel(chan_sel)
  );
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          ale,
  input logic          oe,
  input logic          sample_en,
  input logic [W-1:0]  dac_code,
  input logic          eoc,
  input logic [AW-1:0] chan_sel,
  input logic [W-1:0]  dout,
  input logic          dout_en
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  assert_start_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!sample_en && !eoc));

  assert_sample_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> !sample_en);

  assert_eoc_low_sampling_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> !eoc);

  assert_first_trial_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !start) |=> (dac_code == MSB_ONLY));

  assert_bus_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe) && !$rose(eoc)) |-> $stable(dout));

  assert_bus_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!dout_en && (dout == '0)));

  assert_chan_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(ale) && !$past(ale, 2)) |-> $stable(chan_sel));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start(start), .ale(ale), .oe(oe),
  .sample_en(sample_en), .dac_code(dac_code), .eoc(eoc), .chan_sel(chan_sel),
  .dout(dout), .dout_en(dout_en)
);

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       start_r = 1'b0;
  logic       free_run = 1'b0;
  logic       ale = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       oe = 1'b1;
  logic [7:0] vin = 8'd0;
  logic       start_w, cmp_hi, sample_en, eoc, dout_en;
  logic [7:0] dac_code, dout;
  logic [2:0] chan_sel;

  int         n_cmp = 0;
  int         n_bad = 0;
  int         cyc = 0;
  bit         mon_on = 1'b0;
  bit         done = 1'b0;
  logic       eoc_prev = 1'b1;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  assign start_w = free_run ? eoc : start_r;
  assign cmp_hi  = (vin >= dac_code);   // ideal comparator

  sar_conv_seq u_dut (
    .clk(clk), .arst_n(arst_n), .start(start_w), .ale(ale), .addr(addr),
    .cmp_hi(cmp_hi), .oe(oe), .sample_en(sample_en), .dac_code(dac_code),
    .eoc(eoc), .chan_sel(chan_sel), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: pop the expected code at every end-of-conversion rise
  always @(negedge clk) begin
    if (mon_on) begin
      if (eoc && !eoc_prev) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected completion", dout, 32'hFFFF);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(dout == e, "R4 result", dout, e);
        end
      end
    end
    eoc_prev = eoc;
  end

  // driver: one full conversion of level v, timing and buffer checks
  task automatic run_conv(input logic [7:0] v);
    logic [7:0] old;
    int n;
    old = dout;
    exp_q.push_back(v);
    @(negedge clk);
    vin = v; start_r = 1'b1;
    @(negedge clk);
    start_r = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) chk(sample_en == 1'b1, "R2 sample window", sample_en, 1);
      if (n == 2) begin
        chk(sample_en == 1'b0, "R2 sample one cycle", sample_en, 0);
        chk(dac_code == 8'h80, "R5 first trial", dac_code, 8'h80);
      end
      if (n == 3)
        chk(dac_code == (v[7] ? 8'hC0 : 8'h40), "R5 second trial", dac_code,
            v[7] ? 8'hC0 : 8'h40);
      if (!eoc) chk(dout == old, "R6 old data held", dout, old);
    end while (!eoc && n < 40);
    chk(n == 10, "R3 completion edge", n, 10);
  endtask

  initial begin
    int t_prev;
    logic [7:0] fr_v[3];
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(eoc == 1'b1, "R1 eoc", eoc, 1);
    chk(sample_en == 1'b0, "R1 sample_en", sample_en, 0);
    chk(chan_sel == 3'd0, "R1 chan_sel", chan_sel, 0);
    chk(dout == 8'h00, "R1 result", dout, 0);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(eoc == 1'b1 && dout == 8'h00, "R1 after release", {eoc, dout}, 9'h100);
    mon_on = 1'b1;

    // R2: start held high keeps sequencer cleared
    start_r = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk(sample_en == 1'b0 && eoc == 1'b0, "R2 held", {sample_en, eoc}, 0);
    end
    vin = 8'h5A;
    exp_q.push_back(8'h5A);
    start_r = 1'b0;
    @(negedge clk);
    chk(sample_en == 1'b1, "R2 release", sample_en, 1);
    wait (eoc == 1'b1);
    @(negedge clk);

    // R4/R5/R3/R6: several input patterns, ties at trial levels included
    run_conv(8'h00);
    run_conv(8'hFF);
    run_conv(8'h80);
    run_conv(8'h7F);
    run_conv(8'h55);
    run_conv(8'hA3);
    run_conv(8'h01);

    // R7: restart mid conversion
    begin
      logic [7:0] old;
      int n;
      old = dout;
      @(negedge clk);
      vin = 8'h33; start_r = 1'b1;
      @(negedge clk);
      start_r = 1'b0;
      repeat (6) @(negedge clk);
      chk(eoc == 1'b0 && dout == old, "R7 before restart", {eoc, dout}, {1'b0, old});
      vin = 8'hC8; start_r = 1'b1;
      exp_q.push_back(8'hC8);
      @(negedge clk);
      start_r = 1'b0;
      n = 0;
      do begin
        @(negedge clk);
        n++;
        if (!eoc) chk(dout == old, "R7 abandoned code not loaded", dout, old);
      end while (!eoc && n < 40);
      chk(n == 10, "R7 restart completion edge", n, 10);
    end

    // R8: bus enable
    @(negedge clk);
    oe = 1'b0;
    #1;
    chk(dout_en == 1'b0 && dout == 8'h00, "R8 bus off", {dout_en, dout}, 0);
    @(negedge clk);
    oe = 1'b1;
    #1;
    chk(dout_en == 1'b1 && dout == 8'hC8, "R8 bus on", {dout_en, dout}, 9'h1C8);

    // R9: channel latch
    for (int ch = 0; ch < 8; ch++) begin
      @(negedge clk);
      addr = 3'(ch); ale = 1'b1;
      @(negedge clk);
      ale = 1'b0; addr = ~3'(ch);
      chk(chan_sel == 3'(ch), "R9 capture", chan_sel, ch);
      @(negedge clk);
      chk(chan_sel == 3'(ch), "R9 addr ignored", chan_sel, ch);
    end
    @(negedge clk);
    addr = 3'd5; ale = 1'b1;
    @(negedge clk);
    addr = 3'd2;
    @(negedge clk);
    chk(chan_sel == 3'd5, "R9 held strobe", chan_sel, 5);
    ale = 1'b0;

    // R10: free running with start tied to eoc
    fr_v[0] = 8'h11; fr_v[1] = 8'hEE; fr_v[2] = 8'h6C;
    @(negedge clk);
    exp_q.push_back(fr_v[0]);
    vin = fr_v[0];
    free_run = 1'b1;
    t_prev = 0;
    for (int i = 0; i < 3; i++) begin
      @(posedge eoc);
      @(negedge clk);
      if (i > 0) chk(cyc - t_prev == 11, "R10 period", cyc - t_prev, 11);
      t_prev = cyc;
      if (i < 2) begin
        exp_q.push_back(fr_v[i+1]);
        vin = fr_v[i+1];
      end else begin
        free_run = 1'b0;
      end
    end
    repeat (15) @(negedge clk);
    chk(eoc == 1'b1 && dout == fr_v[2], "R10 stopped", {eoc, dout}, {1'b1, fr_v[2]});
    chk(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule